// File: doc/BRIEF.md
# Two-Level Priority Burst Command Arbiter

This block takes transfer work from two channels, an urgent one and a background one, and turns it into a single stream of burst commands for a slow memory target. Each channel is loaded with a start word address, a word count and a one-cycle start strobe. It then cuts the transfer into commands of at most sixteen words. The address steps up by the length of each command, and the final command carries whatever words are left.

In each cycle the arbiter accepts at most one command into a four-entry first-in first-out queue. The target drains the queue through a valid/ready handshake. The urgent channel wins whenever its command is eligible. The urgent channel also has a readiness input. While that input is low, the background channel fills the free issue cycles. When the readiness input rises, background issue stops in that same cycle.

Commands already in the queue always leave before any command that enters later. A newly granted urgent command can therefore wait behind up to four background bursts, which is 256 bytes. A parameter selects a strict variant instead, in which any pending urgent work blocks the background channel.

Top module: `dma_prio_arb`

## Requirements
- R1: In any cycle at most one of `gnt_hi` and `gnt_lo` is high, and a grant pushes exactly one command into the queue in that cycle.
- R2: When the urgent channel has a command pending, `hi_ready` is high and the queue is not full, `gnt_hi` is high and `gnt_lo` is low.
- R3: When the urgent channel has no eligible command (idle, or `hi_ready` low), a pending background command is granted in the same cycle if the queue is not full. When `hi_ready` rises while the urgent channel is pending, `gnt_lo` drops in that same cycle.
- R4: The queue holds 4 commands. While it is full, neither grant is raised.
- R5: Commands leave on `m_*` in exactly the order in which they were granted. A later urgent command never overtakes queued background commands.
- R6: A transfer of N words produces ceil(N/16) commands. Every command except the last has `m_len`=16, and the last has N minus 16 times the number of earlier commands. The first `m_addr` is the start address, and each later one is the previous address plus the previous length. `m_hi`=1 marks an urgent command and 0 marks a background command.
- R7: `done_hi` / `done_lo` is high for exactly one cycle, in the cycle after the channel's last command is granted.
- R8: While `rst_n` is low, and in the first cycle after it, the queue is empty (`m_valid`=0), both channels are idle, no grant is raised and no done pulse is raised. A reset in mid-transfer discards both the queued and the pending work.
- R9: A start strobe with a word count of zero is ignored, and so is a start strobe to a channel that is still busy. Neither produces a command or a done pulse.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_len` and `m_hi` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_start | input | 1 | Start strobe, urgent channel |
| hi_addr | input | ADDR_W | Start word address, urgent channel |
| hi_words | input | CNT_W | Word count, urgent channel |
| hi_ready | input | 1 | Urgent channel data side ready; low stalls its issue |
| lo_start | input | 1 | Start strobe, background channel |
| lo_addr | input | ADDR_W | Start word address, background channel |
| lo_words | input | CNT_W | Word count, background channel |
| m_valid | output | 1 | Queue head command valid |
| m_ready | input | 1 | Target accepts the head command |
| m_addr | output | ADDR_W | Head command word address |
| m_len | output | LEN_W | Head command word count (1 to 16) |
| m_hi | output | 1 | Head command came from the urgent channel |
| gnt_hi | output | 1 | Urgent command accepted into the queue this cycle |
| gnt_lo | output | 1 | Background command accepted into the queue this cycle |
| done_hi | output | 1 | Urgent transfer fully queued (one-cycle pulse) |
| done_lo | output | 1 | Background transfer fully queued (one-cycle pulse) |

## Verification
A start strobe that is sampled at one clock edge makes the channel busy at that edge. The grant for its first command is therefore visible combinationally in the next cycle, and the command enters the queue at the following edge. It appears on `m_*` one cycle after that. A done pulse shows in the cycle after the edge that accepted the last command. The tasks drive inputs on falling edges and read grants and done pulses at the falling edge of exactly the cycle counted this way, one cycle at a time. They check queue contents only by draining with `m_ready`, so that ordering and burst lengths are compared against a list worked out from the requirements.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   typedef enum logic {
      CH_LO = 1'b0,
      CH_HI = 1'b1
   } chan_e;

   localparam int NUM_CH = 2;
endpackage

// File: rtl/dpa_chan.sv
module dpa_chan #(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 16,
   parameter int BURST_MAX = 16,
   parameter int LEN_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  words,
   input  logic              accept,
   output logic              req,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [LEN_W-1:0]  cmd_len,
   output logic              done
);
   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  rem_q;
   logic              done_q;
   logic              last;

   always_comb begin
      if (rem_q > CNT_W'(BURST_MAX)) cmd_len = LEN_W'(BURST_MAX);
      else                           cmd_len = rem_q[LEN_W-1:0];
      last = (rem_q == CNT_W'(cmd_len));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         addr_q <= '0;
         rem_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start && (words != '0)) begin
               busy_q <= 1'b1;
               addr_q <= start_addr;
               rem_q  <= words;
            end
         end else if (accept) begin
            addr_q <= addr_q + ADDR_W'(cmd_len);
            rem_q  <= rem_q - CNT_W'(cmd_len);
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign req      = busy_q;
   assign cmd_addr = addr_q;
   assign done     = done_q;
endmodule

// File: rtl/dpa_arb.sv
module dpa_arb #(
   parameter bit LO_FILL = 1'b1
) (
   input  logic hi_req,
   input  logic hi_ready,
   input  logic lo_req,
   input  logic q_full,
   output logic gnt_hi,
   output logic gnt_lo
);
   logic hi_elig;
   logic lo_block;

   assign hi_elig = hi_req & hi_ready;

   generate
      if (LO_FILL) begin : g_fill
         assign lo_block = hi_elig;
      end else begin : g_strict
         assign lo_block = hi_req;
      end
   endgenerate

   assign gnt_hi = hi_elig & ~q_full;
   assign gnt_lo = lo_req & ~lo_block & ~q_full;
endmodule

// File: rtl/dpa_fifo.sv
module dpa_fifo #(
   parameter int WIDTH = 38,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         if (do_pop)  rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
   import dpa_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 16,
   parameter int BURST_MAX = 16,
   parameter int QDEPTH    = 4,
   parameter bit LO_FILL   = 1'b1,
   localparam int LEN_W    = $clog2(BURST_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_start,
   input  logic [ADDR_W-1:0] hi_addr,
   input  logic [CNT_W-1:0]  hi_words,
   input  logic              hi_ready,
   input  logic              lo_start,
   input  logic [ADDR_W-1:0] lo_addr,
   input  logic [CNT_W-1:0]  lo_words,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [ADDR_W-1:0] m_addr,
   output logic [LEN_W-1:0]  m_len,
   output logic              m_hi,
   output logic              gnt_hi,
   output logic              gnt_lo,
   output logic              done_hi,
   output logic              done_lo
);
   localparam int ENTRY_W = ADDR_W + LEN_W + 1;

   generate
      if (QDEPTH < 2 || (QDEPTH & (QDEPTH - 1)) != 0) begin : g_bad_depth
         $error("QDEPTH must be a power of two of at least 2");
      end
      if (BURST_MAX < 1) begin : g_bad_burst
         $error("BURST_MAX must be at least 1");
      end
      if (CNT_W < LEN_W) begin : g_bad_cnt
         $error("CNT_W must cover a full burst length");
      end
   endgenerate

   logic              ch_start [NUM_CH];
   logic [ADDR_W-1:0] ch_saddr [NUM_CH];
   logic [CNT_W-1:0]  ch_words [NUM_CH];
   logic              ch_acc   [NUM_CH];
   logic              ch_req   [NUM_CH];
   logic [ADDR_W-1:0] ch_caddr [NUM_CH];
   logic [LEN_W-1:0]  ch_clen  [NUM_CH];
   logic              ch_done  [NUM_CH];

   logic               hi_req, lo_req, q_full, q_empty;
   logic [ENTRY_W-1:0] push_data, head;

   assign ch_start[CH_HI] = hi_start;
   assign ch_saddr[CH_HI] = hi_addr;
   assign ch_words[CH_HI] = hi_words;
   assign ch_start[CH_LO] = lo_start;
   assign ch_saddr[CH_LO] = lo_addr;
   assign ch_words[CH_LO] = lo_words;
   assign ch_acc[CH_HI]   = gnt_hi;
   assign ch_acc[CH_LO]   = gnt_lo;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         dpa_chan #(
            .ADDR_W(ADDR_W), .CNT_W(CNT_W),
            .BURST_MAX(BURST_MAX), .LEN_W(LEN_W)
         ) chan_i (
            .clk(clk), .rst_n(rst_n),
            .start(ch_start[gi]), .start_addr(ch_saddr[gi]), .words(ch_words[gi]),
            .accept(ch_acc[gi]), .req(ch_req[gi]),
            .cmd_addr(ch_caddr[gi]), .cmd_len(ch_clen[gi]), .done(ch_done[gi])
         );
      end
   endgenerate

   assign hi_req  = ch_req[CH_HI];
   assign lo_req  = ch_req[CH_LO];
   assign done_hi = ch_done[CH_HI];
   assign done_lo = ch_done[CH_LO];

   dpa_arb #(.LO_FILL(LO_FILL)) arb_i (
      .hi_req(hi_req), .hi_ready(hi_ready), .lo_req(lo_req),
      .q_full(q_full), .gnt_hi(gnt_hi), .gnt_lo(gnt_lo)
   );

   assign push_data = gnt_hi ? {ch_caddr[CH_HI], ch_clen[CH_HI], 1'b1}
                             : {ch_caddr[CH_LO], ch_clen[CH_LO], 1'b0};

   dpa_fifo #(.WIDTH(ENTRY_W), .DEPTH(QDEPTH)) q_i (
      .clk(clk), .rst_n(rst_n),
      .push(gnt_hi | gnt_lo), .wdata(push_data),
      .pop(m_ready), .rdata(head),
      .empty(q_empty), .full(q_full)
   );

   assign m_valid = ~q_empty;
   assign m_addr  = head[ENTRY_W-1 -: ADDR_W];
   assign m_len   = head[LEN_W:1];
   assign m_hi    = head[0];
endmodule

// File: rtl/dpa_chk.sv
module dpa_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gnt_hi,
   input logic              gnt_lo,
   input logic              hi_req,
   input logic              hi_ready,
   input logic              lo_req,
   input logic              q_full,
   input logic              m_valid,
   input logic              m_ready,
   input logic [ADDR_W-1:0] m_addr,
   input logic [LEN_W-1:0]  m_len,
   input logic              m_hi,
   input logic              done_hi,
   input logic              done_lo
);
   p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(gnt_hi && gnt_lo));

   p_hi_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_req && hi_ready && !q_full) |-> (gnt_hi && !gnt_lo));

   p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_req && !(hi_req && hi_ready) && !q_full) |-> gnt_lo);

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> (!gnt_hi && !gnt_lo));

   p_done_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_hi |-> $past(gnt_hi));

   p_done_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_lo |-> $past(gnt_lo));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=>
         (m_valid && $stable(m_addr) && $stable(m_len) && $stable(m_hi)));
endmodule

bind dma_prio_arb dpa_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .gnt_hi(gnt_hi), .gnt_lo(gnt_lo),
   .hi_req(hi_req), .hi_ready(hi_ready), .lo_req(lo_req), .q_full(q_full),
   .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_len(m_len),
   .m_hi(m_hi), .done_hi(done_hi), .done_lo(done_lo)
);

// File: tb/dma_prio_arb_tb_top.sv
module dma_prio_arb_tb_top;
   localparam int AW = 32;
   localparam int CW = 16;
   localparam int LW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hi_start = 1'b0, lo_start = 1'b0, hi_ready = 1'b1, m_ready = 1'b0;
   logic [AW-1:0] hi_addr = '0, lo_addr = '0;
   logic [CW-1:0] hi_words = '0, lo_words = '0;
   logic          m_valid, m_hi, gnt_hi, gnt_lo, done_hi, done_lo;
   logic [AW-1:0] m_addr;
   logic [LW-1:0] m_len;

   int total = 0;
   int bad = 0;
   int done_hi_cnt = 0;
   int done_lo_cnt = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_prio_arb dut_i (
      .clk(clk), .rst_n(rst_n),
      .hi_start(hi_start), .hi_addr(hi_addr), .hi_words(hi_words), .hi_ready(hi_ready),
      .lo_start(lo_start), .lo_addr(lo_addr), .lo_words(lo_words),
      .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_len(m_len), .m_hi(m_hi),
      .gnt_hi(gnt_hi), .gnt_lo(gnt_lo), .done_hi(done_hi), .done_lo(done_lo)
   );

   always @(posedge clk) begin
      if (rst_n && done_hi) done_hi_cnt <= done_hi_cnt + 1;
      if (rst_n && done_lo) done_lo_cnt <= done_lo_cnt + 1;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic grants(input string req, input logic eh, input logic el);
      check({req, " gnt_hi"}, 64'(gnt_hi), 64'(eh));
      check({req, " gnt_lo"}, 64'(gnt_lo), 64'(el));
   endtask

   task automatic pop_expect(input string req, input logic [AW-1:0] ea,
                             input logic [LW-1:0] el, input logic eh);
      int w = 0;
      while (!m_valid && w < 50) begin
         @(negedge clk);
         w++;
      end
      check({req, " m_valid"}, 64'(m_valid), 64'd1);
      check({req, " m_addr"}, 64'(m_addr), 64'(ea));
      check({req, " m_len"}, 64'(m_len), 64'(el));
      check({req, " m_hi"}, 64'(m_hi), 64'(eh));
      m_ready = 1'b1;
      @(negedge clk);
      m_ready = 1'b0;
   endtask

   task automatic start_ch(input logic hi, input logic [AW-1:0] a, input logic [CW-1:0] n);
      if (hi) begin
         hi_start = 1'b1; hi_addr = a; hi_words = n;
      end else begin
         lo_start = 1'b1; lo_addr = a; lo_words = n;
      end
   endtask

   task automatic end_starts();
      hi_start = 1'b0;
      lo_start = 1'b0;
   endtask

   task automatic t_reset();
      check("R8 reset m_valid", 64'(m_valid), 64'd0);
      grants("R8 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after reset m_valid", 64'(m_valid), 64'd0);
      grants("R8 after reset", 1'b0, 1'b0);
      check("R8 done", 64'({done_hi, done_lo}), 64'd0);
   endtask

   task automatic t_split();
      start_ch(1'b0, 32'h100, 16'd40);
      @(negedge clk); end_starts();
      for (int i = 0; i < 3; i++) begin
         grants("R6 split grant", 1'b0, 1'b1);
         check("R7 no early done", 64'(done_lo), 64'd0);
         @(negedge clk);
      end
      check("R7 done_lo pulse", 64'(done_lo), 64'd1);
      grants("R7 idle after last", 1'b0, 1'b0);
      @(negedge clk);
      check("R7 done_lo one cycle", 64'(done_lo), 64'd0);
      pop_expect("R6 burst0", 32'h100, 5'd16, 1'b0);
      pop_expect("R6 burst1", 32'h110, 5'd16, 1'b0);
      pop_expect("R6 remainder", 32'h120, 5'd8, 1'b0);
   endtask

   task automatic t_priority();
      hi_ready = 1'b1;
      start_ch(1'b1, 32'h200, 16'd32);
      start_ch(1'b0, 32'h300, 16'd32);
      @(negedge clk); end_starts();
      grants("R2 hi wins 0", 1'b1, 1'b0);
      @(negedge clk);
      grants("R2 hi wins 1", 1'b1, 1'b0);
      @(negedge clk);
      grants("R3 lo after hi idle", 1'b0, 1'b1);
      check("R7 done_hi pulse", 64'(done_hi), 64'd1);
      @(negedge clk);
      grants("R1 lo second", 1'b0, 1'b1);
      @(negedge clk);
      check("R7 done_lo pulse", 64'(done_lo), 64'd1);
      pop_expect("R5 order h0", 32'h200, 5'd16, 1'b1);
      pop_expect("R5 order h1", 32'h210, 5'd16, 1'b1);
      pop_expect("R5 order l0", 32'h300, 5'd16, 1'b0);
      pop_expect("R5 order l1", 32'h310, 5'd16, 1'b0);
   endtask

   task automatic t_fill();
      hi_ready = 1'b0;
      start_ch(1'b1, 32'h800, 16'd16);
      start_ch(1'b0, 32'h400, 16'd64);
      @(negedge clk); end_starts();
      grants("R3 fill dead cycle 0", 1'b0, 1'b1);
      @(negedge clk);
      grants("R3 fill dead cycle 1", 1'b0, 1'b1);
      @(negedge clk);
      hi_ready = 1'b1;
      #1;
      grants("R3 lo stops at once", 1'b1, 1'b0);
      @(negedge clk);
      grants("R3 lo resumes", 1'b0, 1'b1);
      check("R7 done_hi", 64'(done_hi), 64'd1);
      @(negedge clk);
      grants("R4 full no grant", 1'b0, 1'b0);
      pop_expect("R5 fill l0", 32'h400, 5'd16, 1'b0);
      pop_expect("R5 fill l1", 32'h410, 5'd16, 1'b0);
      pop_expect("R5 fill h", 32'h800, 5'd16, 1'b1);
      pop_expect("R5 fill l2", 32'h420, 5'd16, 1'b0);
      pop_expect("R5 fill l3", 32'h430, 5'd16, 1'b0);
   endtask

   task automatic t_queue_order();
      start_ch(1'b0, 32'h0, 16'd64);
      @(negedge clk); end_starts();
      repeat (5) @(negedge clk);
      start_ch(1'b1, 32'h900, 16'd16);
      @(negedge clk); end_starts();
      @(negedge clk);
      grants("R4 hi blocked by full queue", 1'b0, 1'b0);
      pop_expect("R5 queued l0", 32'h00, 5'd16, 1'b0);
      pop_expect("R5 queued l1", 32'h10, 5'd16, 1'b0);
      pop_expect("R5 queued l2", 32'h20, 5'd16, 1'b0);
      pop_expect("R5 queued l3", 32'h30, 5'd16, 1'b0);
      pop_expect("R5 hi after 256 bytes", 32'h900, 5'd16, 1'b1);
   endtask

   task automatic t_ignore();
      int dh = done_hi_cnt;
      int dl = done_lo_cnt;
      start_ch(1'b0, 32'hA00, 16'd20);
      start_ch(1'b1, 32'hC00, 16'd0);
      @(negedge clk); end_starts();
      start_ch(1'b0, 32'hB00, 16'd48);
      @(negedge clk); end_starts();
      pop_expect("R9 first", 32'hA00, 5'd16, 1'b0);
      pop_expect("R9 tail", 32'hA10, 5'd4, 1'b0);
      repeat (6) @(negedge clk);
      check("R9 nothing more queued", 64'(m_valid), 64'd0);
      check("R9 no done for zero count", 64'(done_hi_cnt - dh), 64'd0);
      check("R9 one done for busy restart", 64'(done_lo_cnt - dl), 64'd1);
   endtask

   task automatic t_mid_reset();
      start_ch(1'b0, 32'hD00, 16'd64);
      @(negedge clk); end_starts();
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 mid reset queue", 64'(m_valid), 64'd0);
      grants("R8 mid reset channel idle", 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_split();
      t_priority();
      t_fill();
      t_queue_order();
      t_ignore();
      t_mid_reset();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule